// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master from four programmable counts. Each speed class, standard and fast, has its own high count and its own low count, and a speed input chooses the pair. The choice is captured when a START is requested and is then held until the transfer ends, so one transfer always runs at one speed. The block pulls SCL low through an open-drain output enable and lets it go high by releasing it. It watches the synchronised bus level, so a target that holds the line low lengthens the high phase by exactly the time it holds the line.

A byte engine drives the block through three plain level or pulse requests. `req_start` opens a transfer with a START hold period. `req_run` allows each low phase to end. `req_stop` turns the next high phase into the final one, after which the line stays released. While `req_run` and `req_stop` are both low at the end of a low phase, SCL is held low, which stalls the bus. `bit_tick` marks the last cycle of every data-bit high phase, so the byte engine can sample and shift there. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready interface and no back-pressure rule.

Top module: `scl_phase_gen`

## Requirements
- R1: While `enable` is 0, `scl_oe` and `bit_tick` are 0. When `enable` is sampled 0 during a transfer, `scl_oe` is 0 from the next cycle, and a later START works normally.
- R2: When `req_start` is sampled high while idle and enabled, `scl_oe` stays 0 for exactly high-count + 3 cycles, counted from the cycle after the sampling edge. It then goes to 1.
- R3: With `req_run` high and `req_stop` low, each low phase (`scl_oe` = 1) lasts exactly low-count + 1 cycles.
- R4: If the bus follows the output with no stretching, each high phase lasts high-count + 8 cycles. That is the time from `scl_oe` falling to `scl_oe` rising again.
- R5: A high phase does not count until the synchronised SCL has been seen low and then high. If a target releases the line so that `scl_in` is first sampled high at the edge ending cycle c of the phase (cycle 0 being the release), the phase lasts c + high-count + 8 cycles.
- R6: The speed-mode input is sampled only on the edge that accepts `req_start`. Changing `fast_mode` later in the transfer has no effect on any period.
- R7: A write of the count registers while `enable` is 1 is ignored. Later periods still use the old value.
- R8: If `req_run` and `req_stop` are both low when a low phase reaches low-count + 1 cycles, SCL stays low. The phase ends on the edge that first samples `req_run` high, so its length is max(low-count + 1, cycles until that edge).
- R9: If `req_stop` is high at the end of a low phase, SCL is released and never pulled low again. No `bit_tick` is given, and the block returns to idle and accepts a new `req_start`.
- R10: `bit_tick` is a single-cycle pulse on the last cycle of each non-final high phase, and `scl_oe` is 0 in that cycle.
- R11: Register select encoding on `cfg_sel`: 0 is the standard high count, 1 the standard low count, 2 the fast high count, 3 the fast low count. A write takes effect when `cfg_we` is sampled high with `enable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; 0 releases SCL and idles the block |
| fast_mode | input | 1 | Speed select, 1 = fast pair, captured at START |
| cfg_we | input | 1 | Count register write strobe |
| cfg_sel | input | 2 | Count register select (see R11) |
| cfg_wdata | input | CNT_W | Count value to write |
| req_start | input | 1 | Begin a transfer with a START hold |
| req_stop | input | 1 | Make the next high phase the last one |
| req_run | input | 1 | Allow the current low phase to finish |
| scl_in | input | 1 | Observed SCL bus level |
| scl_oe | output | 1 | Open-drain enable, 1 pulls SCL low |
| bit_tick | output | 1 | Last cycle of a data-bit high phase |

## Verification
Every result is measured as a run length of `scl_oe`, sampled on falling clock edges. A START period is counted from the first falling edge after the edge that accepted `req_start`. Low and high phases are counted from the first falling edge at which `scl_oe` shows the new level, until the first one at which it changes, so the two registers of the synchroniser and the state register fall inside the counted window. Stretch release and run grants are driven on a known falling edge inside the phase, and their expected extra cycles come from the requirement formulas. After disable, the release is checked on the very next falling edge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Phases of the serial clock sequencer
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_LOW   = 3'd2,
    PH_REL   = 3'd3,
    PH_HIGH  = 3'd4
  } scl_phase_e;

  // Count register select codes
  localparam logic [1:0] SEL_STD_HI  = 2'd0;
  localparam logic [1:0] SEL_STD_LO  = 2'd1;
  localparam logic [1:0] SEL_FAST_HI = 2'd2;
  localparam logic [1:0] SEL_FAST_LO = 2'd3;
  localparam int         NUM_CNT_REGS = 4;

  // Cycles added to a programmed count in each timed phase
  localparam int START_EXTRA = 3;  // START hold = high count + 3
  localparam int HIGH_TAIL   = 4;  // counted part of a high phase past the count
  localparam int SYNC_DEPTH  = 2;  // bus level synchroniser stages

endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs
  import scl_gen_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STD_HI0 = 492,
  parameter int STD_LO0 = 587,
  parameter int FST_HI0 = 67,
  parameter int FST_LO0 = 161
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             use_fast,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] lo_cnt
);

  logic [CNT_W-1:0] cnt_q [NUM_CNT_REGS];

  function automatic logic [CNT_W-1:0] reset_value(input int idx);
    case (idx)
      0:       return CNT_W'(STD_HI0);
      1:       return CNT_W'(STD_LO0);
      2:       return CNT_W'(FST_HI0);
      default: return CNT_W'(FST_LO0);
    endcase
  endfunction

  // One storage word per select code; writes only land while stopped
  for (genvar g = 0; g < NUM_CNT_REGS; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= reset_value(g);
      end else if (wr_en && !enable && (wr_sel == 2'(g))) begin
        cnt_q[g] <= wr_data;
      end
    end
  end

  // Pair selection follows the captured speed class
  always_comb begin
    if (use_fast) begin
      hi_cnt = cnt_q[SEL_FAST_HI];
      lo_cnt = cnt_q[SEL_FAST_LO];
    end else begin
      hi_cnt = cnt_q[SEL_STD_HI];
      lo_cnt = cnt_q[SEL_STD_LO];
    end
  end

  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(cnt_q[0]) && $stable(cnt_q[1]) &&
                $stable(cnt_q[2]) && $stable(cnt_q[3])));  // R7

endmodule

// File: rtl/scl_level_sync.sv
module scl_level_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fast_mode,
  input  logic             req_start,
  input  logic             req_stop,
  input  logic             req_run,
  input  logic             scl_s,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             mode_fast,
  output logic             scl_oe,
  output logic             bit_tick
);

  localparam int TW = CNT_W + 2;

  scl_phase_e     state_q;
  logic [TW-1:0]  cnt_q;
  logic           stop_pend_q;
  logic           seen_low_q;
  logic           mode_q;

  logic [TW-1:0]  start_lim;
  logic [TW-1:0]  high_lim;
  logic [TW-1:0]  low_lim;
  logic           low_done;
  logic           high_done;
  logic           start_done;
  logic           bus_high_ok;

  assign start_lim  = TW'(hi_cnt) + TW'(START_EXTRA - 1);
  assign high_lim   = TW'(hi_cnt) + TW'(HIGH_TAIL);
  assign low_lim    = TW'(lo_cnt);
  assign start_done = (cnt_q == start_lim);
  assign high_done  = (cnt_q == high_lim);
  assign low_done   = (cnt_q >= low_lim);
  // A high phase starts only after the bus has been seen low then high
  assign bus_high_ok = scl_s && seen_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PH_IDLE;
      cnt_q       <= '0;
      stop_pend_q <= 1'b0;
      seen_low_q  <= 1'b0;
      mode_q      <= 1'b0;
    end else if (!enable) begin
      state_q     <= PH_IDLE;
      cnt_q       <= '0;
      stop_pend_q <= 1'b0;
      seen_low_q  <= 1'b0;
    end else begin
      case (state_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (req_start) begin
            mode_q      <= fast_mode;
            stop_pend_q <= 1'b0;
            state_q     <= PH_START;
          end
        end
        PH_START: begin
          if (start_done) begin
            cnt_q      <= '0;
            seen_low_q <= 1'b0;
            state_q    <= PH_LOW;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_LOW: begin
          if (!scl_s) seen_low_q <= 1'b1;
          if (!low_done) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (req_stop) begin
            stop_pend_q <= 1'b1;
            cnt_q       <= '0;
            state_q     <= PH_REL;
          end else if (req_run) begin
            cnt_q   <= '0;
            state_q <= PH_REL;
          end
        end
        PH_REL: begin
          if (!scl_s) seen_low_q <= 1'b1;
          if (bus_high_ok) begin
            cnt_q   <= '0;
            state_q <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (high_done) begin
            cnt_q      <= '0;
            seen_low_q <= 1'b0;
            if (stop_pend_q) begin
              stop_pend_q <= 1'b0;
              state_q     <= PH_IDLE;
            end else begin
              state_q <= PH_LOW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_q   <= '0;
          state_q <= PH_IDLE;
        end
      endcase
    end
  end

  assign mode_fast = mode_q;
  assign scl_oe    = (state_q == PH_LOW);
  assign bit_tick  = (state_q == PH_HIGH) && high_done && !stop_pend_q;

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_oe);  // R1
  AST_LOW_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LOW) |-> (cnt_q <= low_lim));  // R3
  AST_WAIT_FOR_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == PH_REL && !scl_s) |=> (state_q == PH_REL));  // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE && $past(state_q) != PH_IDLE) |-> $stable(mode_q));  // R6
  AST_TICK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> !scl_oe);  // R10
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);  // R10

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STD_HI0 = 492,
  parameter int STD_LO0 = 587,
  parameter int FST_HI0 = 67,
  parameter int FST_LO0 = 161
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fast_mode,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             req_start,
  input  logic             req_stop,
  input  logic             req_run,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             bit_tick
);

  logic             mode_fast;
  logic             scl_s;
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] lo_cnt;

  scl_cnt_regs #(
    .CNT_W  (CNT_W),
    .STD_HI0(STD_HI0),
    .STD_LO0(STD_LO0),
    .FST_HI0(FST_HI0),
    .FST_LO0(FST_LO0)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .use_fast(mode_fast),
    .hi_cnt  (hi_cnt),
    .lo_cnt  (lo_cnt)
  );

  scl_level_sync #(
    .STAGES (SYNC_DEPTH),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(scl_in),
    .sync_out(scl_s)
  );

  scl_phase_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .fast_mode(fast_mode),
    .req_start(req_start),
    .req_stop (req_stop),
    .req_run  (req_run),
    .scl_s    (scl_s),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt),
    .mode_fast(mode_fast),
    .scl_oe   (scl_oe),
    .bit_tick (bit_tick)
  );

endmodule

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        fast_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        req_start = 1'b0;
  logic        req_stop = 1'b0;
  logic        req_run = 1'b0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        scl_oe;
  logic        bit_tick;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int sh [4] = '{492, 587, 67, 161};

  always #4 clk = ~clk;

  // Open-drain bus: low if the block pulls or a target stretches
  assign scl_in = ~scl_oe & ~stretch;

  scl_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_start(req_start), .req_stop(req_stop), .req_run(req_run),
    .scl_in(scl_in), .scl_oe(scl_oe), .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_start(input int h); return h + 3; endfunction
  function automatic int f_low(input int l, input int hold);
    return (hold > l + 1) ? hold : l + 1;
  endfunction
  function automatic int f_high(input int h, input int s);
    return (s == 0) ? h + 8 : h + 7 + s;
  endfunction

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = val[15:0];
    if (!enable) sh[sel] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Count falling-edge samples while scl_oe keeps level val
  task automatic seg(input bit val, input int lim, input int strn, input int hold,
                     output int len, output int ticks, output bit last);
    len = 0; ticks = 0; last = 1'b0;
    while (scl_oe == val && len < lim) begin
      len++;
      ticks += int'(bit_tick);
      last = bit_tick;
      if (!val && strn > 0 && len == strn) stretch = 1'b0;
      if (val && hold > 0 && len == hold) req_run = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic xfer(input string ctx, input bit fast, input int nbits,
                      input int strn, input int hold);
    int h, l, len, ticks, hl;
    bit last;
    h = fast ? sh[2] : sh[0];
    l = fast ? sh[3] : sh[1];
    if (nbits < 2) hold = 0;
    @(negedge clk);
    fast_mode = fast; req_start = 1'b1; req_run = (hold == 0); req_stop = 1'b0;
    @(negedge clk);
    req_start = 1'b0;
    fast_mode = ~fast;  // must not matter after the START edge (R6)
    seg(1'b0, f_start(h) + 40, 0, 0, len, ticks, last);
    chk(len == f_start(h), $sformatf("R2 start hold %s", ctx), len, f_start(h));
    for (int b = 0; b < nbits; b++) begin
      bit is_last;
      is_last = (b == nbits - 1);
      if (is_last) req_stop = 1'b1;
      stretch = (strn > 0);
      seg(1'b1, f_low(l, hold) + 40, 0, (b == 0) ? hold : 0, len, ticks, last);
      if (b == 0 && hold > 0)
        chk(len == f_low(l, hold), $sformatf("R8 held low %s", ctx), len, f_low(l, hold));
      else
        chk(len == l + 1, $sformatf("R3 low %s", ctx), len, l + 1);
      if (is_last) begin
        hl = f_high(h, strn) + 20;
        seg(1'b0, hl, strn, 0, len, ticks, last);
        chk(len == hl, $sformatf("R9 stays released %s", ctx), len, hl);
        chk(ticks == 0, $sformatf("R9 no tick on stop %s", ctx), ticks, 0);
      end else begin
        seg(1'b0, f_high(h, strn) + 40, strn, 0, len, ticks, last);
        chk(len == f_high(h, strn),
            $sformatf("%s high %s", (strn > 0) ? "R5" : "R4", ctx), len, f_high(h, strn));
        chk(ticks == 1 && last, $sformatf("R10 tick %s", ctx), ticks, 1);
      end
    end
    req_stop = 1'b0; stretch = 1'b0; req_run = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len, ticks;
    bit last;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_oe == 1'b0 && bit_tick == 1'b0, "R1 reset released", int'(scl_oe), 0);

    // R11: distinct values per select, both pairs exercised
    wr(0, 5); wr(1, 9); wr(2, 2); wr(3, 4);
    @(negedge clk) enable = 1'b1;
    xfer("R11 std", 1'b0, 2, 0, 0);
    xfer("R11 fast R6", 1'b1, 2, 0, 0);

    // Zero counts, with and without stretching
    @(negedge clk) enable = 1'b0;
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
    @(negedge clk) enable = 1'b1;
    xfer("zero", 1'b1, 3, 0, 0);
    xfer("zero stretch", 1'b0, 2, 4, 0);

    // R7: writes while enabled are dropped
    wr(1, 40); wr(0, 30);
    xfer("R7 locked", 1'b0, 2, 0, 0);

    // R8: hold low until the run grant arrives late
    @(negedge clk) enable = 1'b0;
    wr(0, 6); wr(1, 3); wr(2, 1); wr(3, 2);
    @(negedge clk) enable = 1'b1;
    xfer("R8 hold", 1'b0, 3, 0, 17);
    xfer("R8 early", 1'b1, 2, 0, 2);

    // R1: disable during a low phase
    @(negedge clk);
    req_start = 1'b1; req_run = 1'b0; fast_mode = 1'b0;
    @(negedge clk) req_start = 1'b0;
    seg(1'b0, 100, 0, 0, len, ticks, last);
    chk(scl_oe == 1'b1, "R1 reached low before disable", int'(scl_oe), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_oe == 1'b0, "R1 release after disable", int'(scl_oe), 0);
    req_run = 1'b1;
    seg(1'b0, 12, 0, 0, len, ticks, last);
    chk(len == 12 && ticks == 0, "R1 stays released", len, 12);
    @(negedge clk) enable = 1'b1;
    xfer("R1 recovered", 1'b0, 1, 0, 0);

    // Random configurations
    for (int it = 0; it < 14; it++) begin
      bit f;
      int nb, st, hd;
      @(negedge clk) enable = 1'b0;
      for (int k = 0; k < 4; k++) wr(k, int'($urandom_range(0, 20)));
      @(negedge clk) enable = 1'b1;
      f  = 1'($urandom_range(0, 1));
      nb = int'($urandom_range(1, 4));
      st = int'($urandom_range(0, 5));
      hd = int'($urandom_range(0, 25));
      xfer($sformatf("rand%0d", it), f, nb, st, hd);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule